// File: doc/BRIEF.md
# Signed Word and Doubleword Multiplier with Overflow

This unit multiplies two 64-bit source operands for a 64-bit fixed-point datapath. It supports three operations. The first is a word multiply that sign-extends the low 32 bits of each source and returns the full 64-bit product. The second is the same word multiply, which also flags when that product does not fit in a signed 32-bit value. The third is a doubleword multiply that returns the low 64 bits of the 128-bit signed product and flags when the product does not fit in a signed 64-bit value.

The datapath works iteratively on magnitudes. On the cycle the operation is accepted, each operand is reduced to its sign and its magnitude. The magnitudes are then multiplied by shift-and-add, taking `DIGIT` multiplier bits per cycle. In a final cycle the unit applies the product sign, tests for overflow and registers the outputs. Every operation takes the same fixed latency of `64/DIGIT + 1` clock edges, which is 17 with the default parameters. The result and the overflow flag hold their values until the next completion.

The controller is a three-state machine. `ST_IDLE` waits for a start and goes to `ST_ACCUM` when `start_i` is sampled high. `ST_ACCUM` adds one digit per cycle and goes to `ST_FINAL` after its last digit. `ST_FINAL` registers the result, the overflow flag and the done pulse, then always returns to `ST_IDLE`.

Top module: `mulw_unit`

## Requirements
- R1: Operation code 0 (word multiply) sign-extends bit 31 of each source over bits 63..32, ignoring the sources' upper halves, and returns the full 64-bit signed product.
- R2: Operation code 1 (word multiply with overflow) returns the same full 64-bit product as code 0, with the upper 32 bits not cleared.
- R3: Operation code 2 (doubleword multiply with overflow) returns the low 64 bits of the 128-bit signed product of the two full 64-bit sources.
- R4: For code 1, `ov_o` is 1 exactly when product bits 63..31 are not all equal, that is, when the product is outside the signed 32-bit range.
- R5: For code 2, `ov_o` is 1 unless bits 127..63 of the 128-bit product are all zeros or all ones.
- R6: For codes 0 and 3, `ov_o` is 0 when the operation completes.
- R7: Operation code 3 gives the same result as code 0.
- R8: `done_o` is high for exactly one cycle, 17 rising edges after the edge that samples `start_i` (with the default `DIGIT` of 4). `result_o` and `ov_o` change only on that edge and then hold until the next completion.
- R9: A `start_i` sampled while an operation is in progress (in `ST_ACCUM` or `ST_FINAL`) is ignored. The running operation's result is unaffected, and no further completion is produced.
- R10: While `rst_i` is high at a clock edge, `result_o`, `ov_o` and `done_o` become 0 and the unit returns to idle.
- R11: A `start_i` sampled in the cycle where `done_o` is high is accepted, so operations can be issued back to back every 18 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, sampled only when idle |
| op_i | input | 2 | Operation: 0 word, 1 word with overflow, 2 doubleword with overflow, 3 same as 0 |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand |
| result_o | output | 64 | Product, held between completions |
| ov_o | output | 1 | Overflow flag of the last completed operation |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The assertions take `start_i` and `op_i` to be known, non-X values at every sampled edge after reset. They also take `op_i` and the sources to matter only on the edge that accepts a start. The bench drives every input from reset onward on falling edges, so nothing is undefined at a rising edge. While an operation runs, the bench deliberately changes the operands and pulses `start_i`, to show that the unit only looks at them when idle.

// File: rtl/mulw_pkg.sv
package mulw_pkg;

    typedef enum logic [1:0] {
        OP_WMUL     = 2'd0,
        OP_WMUL_OV  = 2'd1,
        OP_DMUL_OV  = 2'd2,
        OP_WMUL_ALT = 2'd3
    } mul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FINAL = 2'd2
    } mul_state_e;

endpackage

// File: rtl/mulw_operand.sv
module mulw_operand #(
    parameter int W  = 64,
    parameter int HW = 32
) (
    input  logic [W-1:0] src_i,
    input  logic         word_i,
    output logic         neg_o,
    output logic [W-1:0] mag_o
);
    logic [W-1:0] ext;

    always_comb begin
        if (word_i) begin
            ext = {{(W-HW){src_i[HW-1]}}, src_i[HW-1:0]};
        end else begin
            ext = src_i;
        end
        neg_o = ext[W-1];
        mag_o = ext[W-1] ? (~ext + 1'b1) : ext;
    end

endmodule

// File: rtl/mulw_digit.sv
module mulw_digit #(
    parameter int PW  = 128,
    parameter int DIG = 4
) (
    input  logic [PW-1:0]  acc_i,
    input  logic [PW-1:0]  mcand_i,
    input  logic [DIG-1:0] digit_i,
    output logic [PW-1:0]  acc_o
);
    logic [PW-1:0] pp [DIG];

    for (genvar g = 0; g < DIG; g++) begin : g_pp
        assign pp[g] = digit_i[g] ? (mcand_i << g) : '0;
    end

    always_comb begin
        acc_o = acc_i;
        for (int k = 0; k < DIG; k++) begin
            acc_o = acc_o + pp[k];
        end
    end

endmodule

// File: rtl/mulw_ovf.sv
module mulw_ovf
    import mulw_pkg::*;
#(
    parameter int W  = 64,
    parameter int HW = 32,
    parameter int PW = 128
) (
    input  logic [PW-1:0] prod_i,
    input  mul_op_e       op_i,
    output logic [W-1:0]  res_o,
    output logic          ov_o
);
    logic [W-HW:0]  word_top;
    logic [PW-W:0]  dword_top;
    logic           word_fits;
    logic           dword_fits;

    always_comb begin
        word_top   = prod_i[W-1:HW-1];
        dword_top  = prod_i[PW-1:W-1];
        word_fits  = (&word_top) | ~(|word_top);
        dword_fits = (&dword_top) | ~(|dword_top);
        res_o      = prod_i[W-1:0];
        unique case (op_i)
            OP_WMUL, OP_WMUL_ALT: ov_o = 1'b0;
            OP_WMUL_OV:           ov_o = ~word_fits;
            OP_DMUL_OV:           ov_o = ~dword_fits;
            default:              ov_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mulw_unit.sv
module mulw_unit
    import mulw_pkg::*;
#(
    parameter int W     = 64,
    parameter int DIGIT = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] src_a_i,
    input  logic [W-1:0] src_b_i,
    output logic [W-1:0] result_o,
    output logic         ov_o,
    output logic         done_o
);
    localparam int HW   = W / 2;
    localparam int PW   = 2 * W;
    localparam int ITER = W / DIGIT;
    localparam int CW   = (ITER > 1) ? $clog2(ITER) : 1;

    mul_state_e    st_q, st_d;
    mul_op_e       op_q, op_in;
    logic          neg_q;
    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;
    logic [PW-1:0] acc_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  result_q;
    logic          ov_q;
    logic          done_q;

    logic          word_sel;
    logic [W-1:0]  src   [2];
    logic          neg   [2];
    logic [W-1:0]  mag   [2];
    logic [PW-1:0] acc_next;
    logic [PW-1:0] prod_signed;
    logic [W-1:0]  fin_res;
    logic          fin_ov;
    logic          last_digit;

    assign op_in    = mul_op_e'(op_i);
    assign word_sel = (op_in != OP_DMUL_OV);
    assign src[0]   = src_a_i;
    assign src[1]   = src_b_i;

    for (genvar i = 0; i < 2; i++) begin : g_opnd
        mulw_operand #(.W(W), .HW(HW)) u_opnd (
            .src_i  (src[i]),
            .word_i (word_sel),
            .neg_o  (neg[i]),
            .mag_o  (mag[i])
        );
    end

    mulw_digit #(.PW(PW), .DIG(DIGIT)) u_digit (
        .acc_i   (acc_q),
        .mcand_i (mcand_q),
        .digit_i (mplier_q[DIGIT-1:0]),
        .acc_o   (acc_next)
    );

    assign prod_signed = neg_q ? (~acc_q + 1'b1) : acc_q;

    mulw_ovf #(.W(W), .HW(HW), .PW(PW)) u_ovf (
        .prod_i (prod_signed),
        .op_i   (op_q),
        .res_o  (fin_res),
        .ov_o   (fin_ov)
    );

    assign last_digit = (cnt_q == CW'(ITER - 1));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_i)    st_d = ST_ACCUM;
            ST_ACCUM: if (last_digit) st_d = ST_FINAL;
            ST_FINAL:                 st_d = ST_IDLE;
            default:                  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            op_q     <= OP_WMUL;
            neg_q    <= 1'b0;
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            cnt_q    <= '0;
            result_q <= '0;
            ov_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q     <= op_in;
                        neg_q    <= neg[0] ^ neg[1];
                        mcand_q  <= {{(PW-W){1'b0}}, mag[0]};
                        mplier_q <= mag[1];
                        acc_q    <= '0;
                        cnt_q    <= '0;
                    end
                end
                ST_ACCUM: begin
                    acc_q    <= acc_next;
                    mcand_q  <= mcand_q << DIGIT;
                    mplier_q <= mplier_q >> DIGIT;
                    cnt_q    <= cnt_q + 1'b1;
                end
                ST_FINAL: begin
                    result_q <= fin_res;
                    ov_q     <= fin_ov;
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign result_o = result_q;
    assign ov_o     = ov_q;
    assign done_o   = done_q;

    // R8: completion strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R8: outputs change only on a completion
    p_result_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !done_o |-> ($stable(result_o) && $stable(ov_o)));

    // R9: captured operation survives starts while busy
    p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_ACCUM) |=> ($stable(op_q) && $stable(neg_q)));

    // R6: word multiply never reports overflow
    p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && (op_q == OP_WMUL || op_q == OP_WMUL_ALT)) |-> !ov_o);

    // R11: idle start is always taken
    p_start_accept_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q == ST_IDLE && start_i) |=> (st_q == ST_ACCUM && cnt_q == '0));

endmodule

// File: tb/mulw_unit_test.sv
`timescale 1ns/1ps
module mulw_unit_test;
    localparam int LAT = 17;

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [63:0] src_a_i = '0;
    logic [63:0] src_b_i = '0;
    logic [63:0] result_o;
    logic        ov_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mulw_unit uut (
        .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .result_o(result_o), .ov_o(ov_o), .done_o(done_o)
    );

    function automatic logic [64:0] ref_calc(input logic [1:0] op,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
        logic signed [63:0]  sa, sb, p64;
        logic signed [127:0] wa, wb, p128, lim;
        logic                ov;
        if (op == 2'd2) begin
            wa   = {{64{a[63]}}, a};
            wb   = {{64{b[63]}}, b};
            p128 = wa * wb;
            lim  = 128'sd1 <<< 63;
            ov   = (p128 >= lim) || (p128 < -lim);
            return {ov, p128[63:0]};
        end
        sa  = {{32{a[31]}}, a[31:0]};
        sb  = {{32{b[31]}}, b[31:0]};
        p64 = sa * sb;
        ov  = (op == 2'd1) && ((p64 > 64'sd2147483647) || (p64 < -64'sd2147483648));
        return {ov, p64};
    endfunction

    // behavioural reference: one pending operation and a countdown
    logic        m_busy = 1'b0;
    int          m_cnt = 0;
    logic [1:0]  m_pop = 2'd0;
    logic [1:0]  m_lastop = 2'd0;
    logic [64:0] m_pend = '0;
    logic        e_done = 1'b0;
    logic [63:0] e_res = '0;
    logic        e_ov = 1'b0;

    always @(posedge clk) begin
        if (rst_i) begin
            m_busy = 1'b0; e_done = 1'b0; e_res = '0; e_ov = 1'b0;
        end else begin
            e_done = 1'b0;
            if (m_busy) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_busy = 1'b0; e_done = 1'b1;
                    e_ov = m_pend[64]; e_res = m_pend[63:0]; m_lastop = m_pop;
                end
            end else if (start_i) begin
                m_busy = 1'b1; m_cnt = LAT; m_pop = op_i;
                m_pend = ref_calc(op_i, src_a_i, src_b_i);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string res_tag(input logic [1:0] op);
        case (op)
            2'd1: return "R2 result";
            2'd2: return "R3 result";
            2'd3: return "R7 result";
            default: return "R1 result";
        endcase
    endfunction

    function automatic string ov_tag(input logic [1:0] op);
        case (op)
            2'd1: return "R4 ov";
            2'd2: return "R5 ov";
            default: return "R6 ov";
        endcase
    endfunction

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst_i) begin
            check(done_o == e_done, "R8 R9 R11 done", 64'(done_o), 64'(e_done));
            check(result_o == e_res, res_tag(m_lastop), result_o, e_res);
            check(ov_o == e_ov, ov_tag(m_lastop), 64'(ov_o), 64'(e_ov));
        end
    end

    task automatic run(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(result_o == 0 && ov_o == 0 && done_o == 0, "R10 reset", result_o, 64'd0);
        rst_i = 1'b0;

        run(2'd0, 64'h00000000002F37A0, 64'h41C33D242F816715);
        check(done_o === 1'b1 && result_o == 64'h0008C3146AE0F020, "R1 vector", result_o, 64'h0008C3146AE0F020);
        check(done_o === 1'b1 && result_o == 64'h0008C3146AE0F020, "R8 latency", 64'(done_o), 64'd1);
        run(2'd1, 64'h0407DED115077586, 64'h53778DF3CA992E09);
        check(result_o == 64'hFB9D02730D7735B6, "R2 vector", result_o, 64'hFB9D02730D7735B6);
        run(2'd2, 64'h45F086A5D5887509, 64'd2);
        check(ov_o == 1'b1, "R5 vector ov", 64'(ov_o), 64'd1);
        run(2'd2, 64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF);
        check(ov_o == 1'b1 && result_o == 64'h8000000000000000, "R5 min*-1", result_o, 64'h8000000000000000);
        run(2'd2, 64'h8000000000000000, 64'd1);
        check(ov_o == 1'b0, "R5 min*1", 64'(ov_o), 64'd0);
        run(2'd1, 64'hABCD00007FFFFFFF, 64'd1);
        check(ov_o == 1'b0, "R4 max fits", 64'(ov_o), 64'd0);
        run(2'd1, 64'h0000000080000000, 64'hFFFFFFFFFFFFFFFF);
        check(ov_o == 1'b1 && result_o == 64'h0000000080000000, "R4 -min", result_o, 64'h80000000);
        run(2'd0, 64'h0000000080000000, 64'hFFFFFFFFFFFFFFFF);
        check(ov_o == 1'b0, "R6 word no ov", 64'(ov_o), 64'd0);
        run(2'd3, 64'h1234567880000000, 64'h9999999980000000);
        check(result_o == 64'h4000000000000000 && ov_o == 0, "R7 code3", result_o, 64'h4000000000000000);

        // R9: starts and operand changes during a running operation
        @(negedge clk);
        start_i = 1'b1; op_i = 2'd2; src_a_i = 64'd7; src_b_i = 64'd9;
        @(negedge clk);
        for (int k = 0; k < LAT - 1; k++) begin
            start_i = k[0]; op_i = 2'd1; src_a_i = $urandom; src_b_i = $urandom;
            @(negedge clk);
        end
        start_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1 && result_o == 64'd63, "R9 busy ignored", result_o, 64'd63);
        repeat (LAT + 2) @(negedge clk);
        check(done_o == 1'b0, "R9 no extra done", 64'(done_o), 64'd0);

        // R11: back-to-back issue in the done cycle
        run(2'd0, 64'd5, 64'hFFFFFFFFFFFFFFFD);
        start_i = 1'b1; op_i = 2'd2; src_a_i = 64'd11; src_b_i = 64'd13;
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT) @(negedge clk);
        check(done_o == 1'b1 && result_o == 64'd143, "R11 back to back", result_o, 64'd143);

        for (int n = 0; n < 60; n++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (n % 4 == 1) b = 64'(n) - 64'd30;
            if (n % 5 == 2) a = {32'h0, a[31:0]} >> (n % 24);
            run(2'(n), a, b);
        end
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule